// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block produces an active-low interrupt for each side of a two-port shared memory. The two topmost words of the address space are mailboxes. The all-ones address belongs to the right side. The all-ones address minus one belongs to the left side. When one side writes into the other side's mailbox, the owner's interrupt goes low. The owner releases its interrupt by reading its own mailbox. The mailbox data is held in the shared RAM, which is outside this block. The block only watches each side's control and address lines.

Each side presents an enable, a write strobe, an output enable, an address and a busy input. All of them are active low except the address. The inputs are sampled on the rising clock edge, and the interrupt outputs are registered. An interrupt therefore changes on the edge that samples the triggering access and is visible in the following cycle. A side whose busy input is active has lost arbitration for the location. Such a side can neither raise the peer's interrupt nor clear its own.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is active and after it is released, both interrupt outputs are high (inactive).
- R2: A left-side write (enable low, write strobe low) to the all-ones address, with left busy high, drives the right interrupt low one clock later.
- R3: A right-side write to the all-ones address minus one, with right busy high, drives the left interrupt low one clock later.
- R4: An owner read (enable low, write strobe high, output enable low) of its own mailbox, with its busy high, returns its interrupt to high one clock later.
- R5: A side reading the other side's mailbox leaves both interrupts unchanged.
- R6: A write to the peer's mailbox made while the writer's busy input is low does not assert the peer's interrupt.
- R7: An owner read of its own mailbox made while the owner's busy input is low does not clear its interrupt.
- R8: When a set and a clear of the same interrupt fall in the same cycle, the interrupt ends up low.
- R9: An access with enable high, or a read with output enable high, changes no interrupt.
- R10: Accesses to any address other than the two mailbox addresses, and a side writing its own mailbox, change no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en_n | input | 1 | Left enable, active low |
| l_wr_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_busy_n | input | 1 | Left busy (lost arbitration), active low |
| r_en_n | input | 1 | Right enable, active low |
| r_wr_n | input | 1 | Right write strobe, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_busy_n | input | 1 | Right busy (lost arbitration), active low |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The stimulus runs each set and clear access once with busy inactive and once with busy active. This shows whether busy gating is applied to the correct side and to the correct action. Reads of the peer's mailbox, reads with output enable high, accesses with enable high and writes to a side's own mailbox are placed between a set and its clear. Each of these would wrongly release or raise a flag that is already pending. A cycle with a set and a clear of the same flag shows which of the two wins. A set of both flags in the same cycle shows that the two ports are kept independent.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   localparam int unsigned SIDE_L = 0;
   localparam int unsigned SIDE_R = 1;
   localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
   import mbox_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
   parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
   input  logic              en_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy_n,
   output logic              post_peer,
   output logic              take_own
);
   acc_kind_e kind;

   always_comb begin
      if (en_n)       kind = ACC_NONE;
      else if (!wr_n) kind = ACC_WRITE;
      else if (!oe_n) kind = ACC_READ;
      else            kind = ACC_NONE;
   end

   assign post_peer = (kind == ACC_WRITE) && (addr == PEER_BOX) && busy_n;
   assign take_own  = (kind == ACC_READ)  && (addr == OWN_BOX)  && busy_n;
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   logic irq_n_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set)      irq_n_d = 1'b0;
            else if (clr) irq_n_d = 1'b1;
            else          irq_n_d = irq_n;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr)      irq_n_d = 1'b1;
            else if (set) irq_n_d = 1'b0;
            else          irq_n_d = irq_n;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= irq_n_d;
   end

   generate
      if (SET_WINS) begin : g_chk
         // R8: a set, even with a clear present, always lands
         assert_set_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set |=> !irq_n);
      end
   endgenerate
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
   import mbox_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 15,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en_n,
   input  logic              l_wr_n,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_busy_n,
   input  logic              r_en_n,
   input  logic              r_wr_n,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_busy_n,
   output logic              l_irq_n,
   output logic              r_irq_n
);
   localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("mbox_irq_ctrl: ADDR_W must be 2..32");
      end
   endgenerate

   logic [NUM_SIDES-1:0] en_v, wr_v, oe_v, busy_v, post_v, take_v, irq_v;
   logic [ADDR_W-1:0]    addr_v [NUM_SIDES];

   assign en_v   = {r_en_n,   l_en_n};
   assign wr_v   = {r_wr_n,   l_wr_n};
   assign oe_v   = {r_oe_n,   l_oe_n};
   assign busy_v = {r_busy_n, l_busy_n};
   assign addr_v[SIDE_L] = l_addr;
   assign addr_v[SIDE_R] = r_addr;

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         localparam logic [ADDR_W-1:0] OWN  = (s == SIDE_L) ? BOX_L : BOX_R;
         localparam logic [ADDR_W-1:0] PEER = (s == SIDE_L) ? BOX_R : BOX_L;

         mbox_port_decode #(
            .ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)
         ) u_dec (
            .en_n(en_v[s]), .wr_n(wr_v[s]), .oe_n(oe_v[s]),
            .addr(addr_v[s]), .busy_n(busy_v[s]),
            .post_peer(post_v[s]), .take_own(take_v[s])
         );

         mbox_irq_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set(post_v[NUM_SIDES-1-s]), .clr(take_v[s]),
            .irq_n(irq_v[s])
         );
      end
   endgenerate

   assign l_irq_n = irq_v[SIDE_L];
   assign r_irq_n = irq_v[SIDE_R];

   // Port-level checks
   assert_left_sets_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en_n && !l_wr_n && l_addr == BOX_R && l_busy_n) |=> !r_irq_n);
   assert_right_sets_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_en_n && !r_wr_n && r_addr == BOX_L && r_busy_n) |=> !l_irq_n);
   assert_right_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_en_n && r_wr_n && !r_oe_n && r_addr == BOX_R && r_busy_n &&
       !(!l_en_n && !l_wr_n && l_addr == BOX_R && l_busy_n)) |=> r_irq_n);
   assert_busy_blocks_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en_n && !l_wr_n && l_addr == BOX_R && !l_busy_n && r_irq_n) |=> r_irq_n);
   assert_busy_blocks_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en_n && l_wr_n && !l_oe_n && l_addr == BOX_L && !l_busy_n && !l_irq_n)
      |=> !l_irq_n);
   assert_disabled_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (l_en_n && r_en_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/mbox_irq_ctrl_tb.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_tb_top;
   localparam int unsigned AW = 15;
   localparam logic [AW-1:0] TOP = {AW{1'b1}};
   localparam logic [AW-1:0] TOP1 = TOP - 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_en_n = 1, l_wr_n = 1, l_oe_n = 1, l_busy_n = 1;
   logic r_en_n = 1, r_wr_n = 1, r_oe_n = 1, r_busy_n = 1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_irq_n, r_irq_n;

   int checks = 0;
   int failures = 0;
   bit model_l = 1'b1;
   bit model_r = 1'b1;

   always #2 clk = ~clk;

   mbox_irq_ctrl #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
      .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
      .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
   );

   task automatic compare(input string tag);
      checks++;
      if (l_irq_n !== model_l || r_irq_n !== model_r) begin
         failures++;
         $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected l=%b r=%b",
                  tag, l_irq_n, r_irq_n, model_l, model_r);
      end
   endtask

   task automatic idle_inputs();
      l_en_n = 1; l_wr_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0;
      r_en_n = 1; r_wr_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0;
   endtask

   // One clock: update the behavioural model from the sampled inputs, then compare
   task automatic cyc(input string tag);
      bit lw, lr, rw, rr, set_r, clr_r, set_l, clr_l;
      @(posedge clk);
      lw = !l_en_n && !l_wr_n;
      lr = !l_en_n && l_wr_n && !l_oe_n;
      rw = !r_en_n && !r_wr_n;
      rr = !r_en_n && r_wr_n && !r_oe_n;
      set_r = lw && l_addr == TOP  && l_busy_n;
      clr_r = rr && r_addr == TOP  && r_busy_n;
      set_l = rw && r_addr == TOP1 && r_busy_n;
      clr_l = lr && l_addr == TOP1 && l_busy_n;
      if (set_r) model_r = 0; else if (clr_r) model_r = 1;
      if (set_l) model_l = 0; else if (clr_l) model_l = 1;
      @(negedge clk);
      compare(tag);
      idle_inputs();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 during reset");
      rst_n = 1'b1;
      cyc("R1 after reset");

      l_en_n = 0; l_wr_n = 0; l_addr = TOP; l_busy_n = 0; cyc("R6 left busy write");
      l_en_n = 0; l_wr_n = 0; l_addr = TOP; cyc("R2 left posts right");
      l_en_n = 0; l_oe_n = 0; l_addr = TOP; cyc("R5 left reads right box");
      r_en_n = 0; r_oe_n = 0; r_addr = TOP; r_busy_n = 0; cyc("R7 right busy read");
      r_en_n = 0; r_oe_n = 1; r_addr = TOP; cyc("R9 read with oe high");
      r_en_n = 1; r_oe_n = 0; r_addr = TOP; cyc("R9 read with en high");
      r_en_n = 0; r_wr_n = 0; r_addr = TOP; cyc("R10 right writes own box");
      r_en_n = 0; r_oe_n = 0; r_addr = TOP - 2; cyc("R10 right reads other address");
      r_en_n = 0; r_oe_n = 0; r_addr = TOP; cyc("R4 right clears");

      r_en_n = 0; r_wr_n = 0; r_addr = TOP1; r_busy_n = 0; cyc("R6 right busy write");
      r_en_n = 0; r_wr_n = 0; r_addr = TOP1; cyc("R3 right posts left");
      r_en_n = 0; r_oe_n = 0; r_addr = TOP1; cyc("R5 right reads left box");
      l_en_n = 0; l_wr_n = 0; l_addr = TOP - 3; cyc("R10 left writes other address");
      l_en_n = 0; l_oe_n = 0; l_addr = TOP1; l_busy_n = 0; cyc("R7 left busy read");
      l_en_n = 0; l_oe_n = 0; l_addr = TOP1;
      r_en_n = 0; r_wr_n = 0; r_addr = TOP1; cyc("R8 set beats clear");
      l_en_n = 0; l_oe_n = 0; l_addr = TOP1; cyc("R4 left clears");

      l_en_n = 1; l_wr_n = 0; l_addr = TOP; cyc("R9 write with en high");
      l_en_n = 0; l_wr_n = 0; l_addr = TOP;
      r_en_n = 0; r_wr_n = 0; r_addr = TOP1; cyc("R2 R3 both posted");
      r_en_n = 0; r_oe_n = 0; r_addr = TOP;
      l_en_n = 0; l_wr_n = 0; l_addr = TOP; cyc("R8 right set beats clear");
      r_en_n = 0; r_oe_n = 0; r_addr = TOP;
      l_en_n = 0; l_oe_n = 0; l_addr = TOP1; cyc("R4 both clear");
      cyc("R10 idle");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule